// File: doc/BRIEF.md
# Security Code Verifier with Error Counter

This block decides whether the memory it sits beside may be erased or written. It keeps a multi-byte secret code and a small error counter. A host opens a verification attempt with a start strobe and then presents one comparison byte per strobe. Opening an attempt clears one set bit of the counter straight away. An attempt that is abandoned part-way therefore still costs a try. If every presented byte equals its stored counterpart, the counter is refilled to all ones and the unlock flag rises. The flag then stays high until reset.

Each failed attempt leaves the counter one bit poorer. Once no set bit remains and no attempt is open, the device is locked for good: new attempts are refused and nothing can raise the unlock flag. Software may clear counter bits at any time, but it can never set them. The stored code can be changed only while writes are permitted. On the read side, the counter is visible and the code bytes always read as zero. Reset stands in for loading the nonvolatile contents at power-up: the counter and the code take their parameter defaults.

Top module: `sec_gate`

## Requirements
- R1: After reset the counter holds all ones (3'b111), `unlocked`, `locked` and `wr_permit` are low, and code byte i holds `INIT_CODE[8i+7:8i]` (default bytes 0,1,2 = 8'h5A, 8'hC3, 8'h17).
- R2: A start strobe while the counter is non-zero clears the lowest set bit of the counter on that clock edge, whether or not the attempt is ever completed.
- R3: Bytes given after a start are compared with code byte 0, then 1, then 2. If all three match, the counter becomes 3'b111 and `unlocked` rises on the edge that takes the third byte.
- R4: If any byte of an attempt differs, the attempt closes after its third byte without setting `unlocked`, and the counter keeps the value left by the start.
- R5: Three failed attempts bring the counter to 3'b000. With no attempt open, `locked` is then high and stays high, starts are refused, and `unlocked` can never rise. An attempt already open when the counter reaches zero may still succeed.
- R6: Once `unlocked` is high it stays high until reset, even through later failed attempts.
- R7: A counter write sets the counter to its old value ANDed with `ec_wr_val`. It acts in any state, including locked, and it closes any open attempt without a verdict. Within one cycle it takes priority over a start or a byte.
- R8: A code write updates byte `code_wr_idx` only while `wr_permit` (`unlocked` and not `locked`) is high. Otherwise it is ignored.
- R9: `rd_sel` = 0 reads the counter zero-extended to 8 bits. Any other `rd_sel` value reads 8'h00, whatever the code holds.
- R10: A byte strobe with no attempt open is ignored. A start while an attempt is open restarts the attempt at byte 0 and clears another counter bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; also reloads stored contents |
| att_start | input | 1 | Opens (or reopens) a verification attempt |
| att_byte_vld | input | 1 | Strobe for a comparison byte |
| att_byte | input | 8 | Comparison byte |
| ec_wr_en | input | 1 | Counter write strobe (clear-only) |
| ec_wr_val | input | 3 | Mask ANDed into the counter |
| code_wr_en | input | 1 | Code byte write strobe |
| code_wr_idx | input | 2 | Code byte index |
| code_wr_data | input | 8 | New code byte |
| rd_sel | input | 2 | Security area read select |
| rd_data | output | 8 | Masked read data |
| err_count | output | 3 | Current counter value |
| unlocked | output | 1 | Code verified since reset |
| locked | output | 1 | Counter exhausted, no attempt open |
| wr_permit | output | 1 | Memory erase/write allowed |

## Verification
On every cycle, the assertions check that the counter never gains a bit except through a successful match, and that each start removes exactly one bit. They also check that the lock and unlock flags never fall once set, that a successful match refills the counter, and that code reads are always zero. Only the bench scenarios can show the behaviours that depend on stored data: that the byte order matters, that a third attempt made on the last bit can still succeed, that a blocked code write leaves the old code working, and that a counter write abandons an open attempt.

// File: rtl/sec_gate_pkg.sv
package sec_gate_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_CMP  = 1'b1
  } att_state_e;

  // Remove the least significant set bit of a value.
  function automatic logic [31:0] clear_low_one(input logic [31:0] v);
    return v & (v - 32'd1);
  endfunction

endpackage

// File: rtl/sec_err_counter.sv
module sec_err_counter
  import sec_gate_pkg::*;
#(
  parameter int unsigned EC_W    = 3,
  parameter logic [EC_W-1:0] INIT_EC = '1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            consume,
  input  logic            restore,
  input  logic            wr_en,
  input  logic [EC_W-1:0] wr_val,
  output logic [EC_W-1:0] ec_q,
  output logic            ec_zero
);

  logic [EC_W-1:0] ec_d;
  logic            ec_en;

  always_comb begin
    ec_d = ec_q;
    if (restore) begin
      ec_d = '1;
    end else if (consume) begin
      ec_d = EC_W'(clear_low_one(32'(ec_q)));
    end
    if (wr_en) begin
      ec_d = ec_d & wr_val;
    end
  end

  assign ec_en   = restore | consume | wr_en;
  assign ec_zero = (ec_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ec_q <= INIT_EC;
    end else if (ec_en) begin
      ec_q <= ec_d;
    end
  end

  // R2: a start removes exactly one bit
  a_r2_one_bit_per_try: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && !restore && !wr_en && ec_q != '0)
      |=> ($countones(ec_q) + 1 == $countones($past(ec_q))))
    else $error("counter did not lose exactly one bit");

  // R7: without a successful match the counter only loses bits
  a_r7_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
    !restore |=> ((ec_q & ~$past(ec_q)) == '0))
    else $error("counter gained a bit without a match");

  // R3: a successful match refills the counter
  a_r3_refill: assert property (@(posedge clk) disable iff (!rst_n)
    (restore && !wr_en) |=> (ec_q == '1))
    else $error("counter not refilled after match");

endmodule

// File: rtl/sec_code_bank.sv
module sec_code_bank #(
  parameter int unsigned CODE_BYTES = 3,
  parameter int unsigned BYTE_W     = 8,
  parameter int unsigned IDX_W      = 2,
  parameter logic [CODE_BYTES*BYTE_W-1:0] INIT_CODE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  cmp_idx,
  output logic [BYTE_W-1:0] ref_byte
);

  logic [CODE_BYTES-1:0][BYTE_W-1:0] code_q;
  logic [CODE_BYTES-1:0][BYTE_W-1:0] code_d;
  logic [CODE_BYTES-1:0]             byte_we;

  for (genvar g = 0; g < CODE_BYTES; g++) begin : g_byte
    assign byte_we[g] = wr_en && (wr_idx == IDX_W'(g));
    assign code_d[g]  = byte_we[g] ? wr_data : code_q[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        code_q[g] <= INIT_CODE[g*BYTE_W +: BYTE_W];
      end else if (byte_we[g]) begin
        code_q[g] <= code_d[g];
      end
    end
  end

  always_comb begin
    ref_byte = '0;
    for (int i = 0; i < CODE_BYTES; i++) begin
      if (cmp_idx == IDX_W'(i)) begin
        ref_byte = code_q[i];
      end
    end
  end

  // R8: stored code only changes through a granted write
  a_r8_code_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(code_q))
    else $error("code changed without a granted write");

endmodule

// File: rtl/sec_attempt_fsm.sv
module sec_attempt_fsm
  import sec_gate_pkg::*;
#(
  parameter int unsigned CODE_BYTES = 3,
  parameter int unsigned BYTE_W     = 8,
  parameter int unsigned IDX_W      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              att_start,
  input  logic              att_byte_vld,
  input  logic [BYTE_W-1:0] att_byte,
  input  logic              ec_wr_en,
  input  logic              ec_zero,
  input  logic [BYTE_W-1:0] ref_byte,
  output logic [IDX_W-1:0]  cmp_idx,
  output logic              active,
  output logic              consume,
  output logic              restore,
  output logic              unlock_q
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CODE_BYTES - 1);

  att_state_e       st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             miss_q, miss_d;
  logic             unlock_d;
  logic             byte_take;
  logic             is_last;
  logic             hit;

  assign active    = (st_q == ST_CMP);
  assign cmp_idx   = idx_q;
  assign hit       = (att_byte == ref_byte);
  assign is_last   = (idx_q == LAST_IDX);
  assign consume   = att_start && !ec_wr_en && !ec_zero;
  assign byte_take = active && att_byte_vld && !att_start && !ec_wr_en;
  assign restore   = byte_take && is_last && !miss_q && hit;
  assign unlock_d  = unlock_q || restore;

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    miss_d = miss_q;
    if (ec_wr_en) begin
      st_d = ST_IDLE;
    end else if (att_start) begin
      if (ec_zero) begin
        st_d = ST_IDLE;
      end else begin
        st_d   = ST_CMP;
        idx_d  = '0;
        miss_d = 1'b0;
      end
    end else if (byte_take) begin
      miss_d = miss_q || !hit;
      if (is_last) begin
        st_d = ST_IDLE;
      end else begin
        idx_d = idx_q + IDX_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      idx_q    <= '0;
      miss_q   <= 1'b0;
      unlock_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      idx_q    <= idx_d;
      miss_q   <= miss_d;
      unlock_q <= unlock_d;
    end
  end

  // R6: unlock never falls before reset
  a_r6_unlock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    unlock_q |=> unlock_q)
    else $error("unlock flag dropped");

  // R10: the byte pointer stays inside the code while comparing
  a_r10_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (idx_q <= LAST_IDX))
    else $error("byte index out of range");

  // R7: a counter write leaves no attempt open
  a_r7_write_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    ec_wr_en |=> !active)
    else $error("attempt survived a counter write");

endmodule

// File: rtl/sec_gate.sv
module sec_gate #(
  parameter int unsigned CODE_BYTES = 3,
  parameter int unsigned BYTE_W     = 8,
  parameter int unsigned EC_W       = 3,
  parameter logic [CODE_BYTES*BYTE_W-1:0] INIT_CODE = 24'h17C35A,
  parameter logic [EC_W-1:0] INIT_EC = '1,
  localparam int unsigned IDX_W = (CODE_BYTES > 1) ? $clog2(CODE_BYTES) : 1,
  localparam int unsigned SEL_W = $clog2(CODE_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              att_start,
  input  logic              att_byte_vld,
  input  logic [BYTE_W-1:0] att_byte,
  input  logic              ec_wr_en,
  input  logic [EC_W-1:0]   ec_wr_val,
  input  logic              code_wr_en,
  input  logic [IDX_W-1:0]  code_wr_idx,
  input  logic [BYTE_W-1:0] code_wr_data,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [BYTE_W-1:0] rd_data,
  output logic [EC_W-1:0]   err_count,
  output logic              unlocked,
  output logic              locked,
  output logic              wr_permit
);

  logic [EC_W-1:0]   ec_q;
  logic              ec_zero;
  logic              active;
  logic              consume;
  logic              restore;
  logic              unlock_q;
  logic [IDX_W-1:0]  cmp_idx;
  logic [BYTE_W-1:0] ref_byte;
  logic              code_we;

  sec_err_counter #(
    .EC_W    (EC_W),
    .INIT_EC (INIT_EC)
  ) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .consume (consume),
    .restore (restore),
    .wr_en   (ec_wr_en),
    .wr_val  (ec_wr_val),
    .ec_q    (ec_q),
    .ec_zero (ec_zero)
  );

  sec_attempt_fsm #(
    .CODE_BYTES (CODE_BYTES),
    .BYTE_W     (BYTE_W),
    .IDX_W      (IDX_W)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .att_start    (att_start),
    .att_byte_vld (att_byte_vld),
    .att_byte     (att_byte),
    .ec_wr_en     (ec_wr_en),
    .ec_zero      (ec_zero),
    .ref_byte     (ref_byte),
    .cmp_idx      (cmp_idx),
    .active       (active),
    .consume      (consume),
    .restore      (restore),
    .unlock_q     (unlock_q)
  );

  assign locked    = ec_zero && !active;
  assign unlocked  = unlock_q;
  assign wr_permit = unlock_q && !locked;
  assign err_count = ec_q;
  assign code_we   = code_wr_en && wr_permit && (32'(code_wr_idx) < CODE_BYTES);

  sec_code_bank #(
    .CODE_BYTES (CODE_BYTES),
    .BYTE_W     (BYTE_W),
    .IDX_W      (IDX_W),
    .INIT_CODE  (INIT_CODE)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (code_we),
    .wr_idx   (code_wr_idx),
    .wr_data  (code_wr_data),
    .cmp_idx  (cmp_idx),
    .ref_byte (ref_byte)
  );

  always_comb begin
    rd_data = '0;
    if (rd_sel == '0) begin
      rd_data = BYTE_W'(ec_q);
    end
  end

  // R5: lockout is permanent
  a_r5_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked)
    else $error("lock released");

  // R5: a locked device that was never unlocked stays so
  a_r5_no_late_unlock: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !unlocked) |=> !unlocked)
    else $error("unlock after lockout");

  // R9: code bytes never appear on the read port
  a_r9_code_hidden: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel != '0) |-> (rd_data == '0))
    else $error("code byte leaked on read");

  // R8: no code update reaches the bank while writes are barred
  a_r8_write_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_permit |-> !code_we)
    else $error("code write granted without permit");

endmodule

// File: tb/sec_gate_tb.sv
module sec_gate_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       att_start = 1'b0;
  logic       att_byte_vld = 1'b0;
  logic [7:0] att_byte = '0;
  logic       ec_wr_en = 1'b0;
  logic [2:0] ec_wr_val = '0;
  logic       code_wr_en = 1'b0;
  logic [1:0] code_wr_idx = '0;
  logic [7:0] code_wr_data = '0;
  logic [1:0] rd_sel = '0;
  logic [7:0] rd_data;
  logic [2:0] err_count;
  logic       unlocked;
  logic       locked;
  logic       wr_permit;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  sec_gate u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .att_start    (att_start),
    .att_byte_vld (att_byte_vld),
    .att_byte     (att_byte),
    .ec_wr_en     (ec_wr_en),
    .ec_wr_val    (ec_wr_val),
    .code_wr_en   (code_wr_en),
    .code_wr_idx  (code_wr_idx),
    .code_wr_data (code_wr_data),
    .rd_sel       (rd_sel),
    .rd_data      (rd_data),
    .err_count    (err_count),
    .unlocked     (unlocked),
    .locked       (locked),
    .wr_permit    (wr_permit)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic op_start();
    @(negedge clk);
    att_start = 1'b1;
    @(negedge clk);
    att_start = 1'b0;
  endtask

  task automatic op_byte(input logic [7:0] b);
    @(negedge clk);
    att_byte_vld = 1'b1;
    att_byte     = b;
    @(negedge clk);
    att_byte_vld = 1'b0;
  endtask

  task automatic op_ecwr(input logic [2:0] v);
    @(negedge clk);
    ec_wr_en  = 1'b1;
    ec_wr_val = v;
    @(negedge clk);
    ec_wr_en  = 1'b0;
  endtask

  task automatic op_codewr(input logic [1:0] i, input logic [7:0] d);
    @(negedge clk);
    code_wr_en   = 1'b1;
    code_wr_idx  = i;
    code_wr_data = d;
    @(negedge clk);
    code_wr_en   = 1'b0;
  endtask

  task automatic attempt(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
    op_start();
    op_byte(b0);
    op_byte(b1);
    op_byte(b2);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1", "counter", 32'(err_count), 32'h7);
    check("R1", "unlocked", 32'(unlocked), 32'h0);
    check("R1", "locked", 32'(locked), 32'h0);
    check("R1", "wr_permit", 32'(wr_permit), 32'h0);
    rd_sel = 2'd0; #1;
    check("R9", "read counter", 32'(rd_data), 32'h07);
    for (int s = 1; s < 4; s++) begin
      rd_sel = 2'(s); #1;
      check("R9", "read code hidden", 32'(rd_data), 32'h00);
    end
    rd_sel = 2'd0;
  endtask

  task automatic t_good();
    do_reset();
    op_start();
    check("R2", "counter after start", 32'(err_count), 32'h6);
    op_byte(8'h5A);
    op_byte(8'hC3);
    check("R3", "no unlock before last byte", 32'(unlocked), 32'h0);
    op_byte(8'h17);
    check("R3", "counter refilled", 32'(err_count), 32'h7);
    check("R3", "unlocked", 32'(unlocked), 32'h1);
    check("R8", "wr_permit", 32'(wr_permit), 32'h1);
  endtask

  task automatic t_bad();
    do_reset();
    attempt(8'h5A, 8'h00, 8'h17);
    check("R4", "counter after miss", 32'(err_count), 32'h6);
    check("R4", "no unlock", 32'(unlocked), 32'h0);
    attempt(8'hC3, 8'h5A, 8'h17);
    check("R3", "order matters", 32'(err_count), 32'h4);
    check("R3", "swapped bytes no unlock", 32'(unlocked), 32'h0);
    op_byte(8'h5A);
    check("R10", "stray byte ignored", 32'(err_count), 32'h4);
    op_start();
    check("R2", "abandoned start consumes", 32'(err_count), 32'h0);
    check("R5", "open attempt not locked", 32'(locked), 32'h0);
  endtask

  task automatic t_lockout();
    do_reset();
    attempt(8'h00, 8'h00, 8'h00);
    attempt(8'h5A, 8'hC3, 8'h18);
    check("R5", "two misses not locked", 32'(locked), 32'h0);
    attempt(8'hFF, 8'hC3, 8'h17);
    check("R5", "counter exhausted", 32'(err_count), 32'h0);
    check("R5", "locked", 32'(locked), 32'h1);
    attempt(8'h5A, 8'hC3, 8'h17);
    check("R5", "correct code refused", 32'(unlocked), 32'h0);
    check("R5", "counter stays zero", 32'(err_count), 32'h0);
    check("R5", "still locked", 32'(locked), 32'h1);
    op_ecwr(3'b111);
    check("R7", "write cannot refill", 32'(err_count), 32'h0);
    check("R8", "no permit when locked", 32'(wr_permit), 32'h0);
  endtask

  task automatic t_last_chance();
    do_reset();
    attempt(8'h00, 8'hC3, 8'h17);
    attempt(8'h5A, 8'h00, 8'h17);
    op_start();
    check("R5", "last try counter", 32'(err_count), 32'h0);
    check("R5", "last try open not locked", 32'(locked), 32'h0);
    op_byte(8'h5A);
    op_byte(8'hC3);
    op_byte(8'h17);
    check("R5", "last try succeeds", 32'(unlocked), 32'h1);
    check("R5", "last try refills", 32'(err_count), 32'h7);
  endtask

  task automatic t_sticky();
    do_reset();
    attempt(8'h5A, 8'hC3, 8'h17);
    attempt(8'h01, 8'h02, 8'h03);
    check("R6", "unlock held after miss", 32'(unlocked), 32'h1);
    check("R6", "counter after miss", 32'(err_count), 32'h6);
    check("R6", "permit held", 32'(wr_permit), 32'h1);
  endtask

  task automatic t_ecwrite();
    do_reset();
    op_ecwr(3'b101);
    check("R7", "clear bit", 32'(err_count), 32'h5);
    op_ecwr(3'b111);
    check("R7", "cannot set bit", 32'(err_count), 32'h5);
    op_start();
    check("R2", "lowest set bit cleared", 32'(err_count), 32'h4);
    op_ecwr(3'b111);
    op_byte(8'h5A);
    op_byte(8'hC3);
    op_byte(8'h17);
    check("R7", "aborted attempt no unlock", 32'(unlocked), 32'h0);
    check("R7", "aborted attempt counter", 32'(err_count), 32'h4);
  endtask

  task automatic t_codewr();
    do_reset();
    op_codewr(2'd0, 8'hAA);
    attempt(8'h5A, 8'hC3, 8'h17);
    check("R8", "barred write left code", 32'(unlocked), 32'h1);
    check("R8", "barred write counter", 32'(err_count), 32'h7);
    op_codewr(2'd0, 8'hAA);
    rd_sel = 2'd1; #1;
    check("R9", "new code hidden", 32'(rd_data), 32'h00);
    rd_sel = 2'd0;
    attempt(8'h5A, 8'hC3, 8'h17);
    check("R8", "old code now fails", 32'(err_count), 32'h6);
    attempt(8'hAA, 8'hC3, 8'h17);
    check("R8", "new code matches", 32'(err_count), 32'h7);
  endtask

  task automatic t_restart();
    do_reset();
    op_start();
    op_byte(8'h5A);
    op_start();
    check("R10", "restart consumes", 32'(err_count), 32'h4);
    op_byte(8'h5A);
    op_byte(8'hC3);
    op_byte(8'h17);
    check("R10", "restart from byte 0", 32'(unlocked), 32'h1);
    check("R10", "restart refill", 32'(err_count), 32'h7);
  endtask

  initial begin
    t_reset();
    t_good();
    t_bad();
    t_lockout();
    t_last_chance();
    t_sticky();
    t_ecwrite();
    t_codewr();
    t_restart();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule